// File: doc/BRIEF.md
# Soft-Mute Gain Ramp Controller

This block owns the live 8-bit gain code of each of two audio channels. Code X stands for 0.5·(X−255) dB for X from 1 to 255; code 0 is full mute and 0xFF is unity gain. Software writes attenuation codes for left and right into held registers. A write whose load flag is clear only stores its code. A write whose load flag is set transfers both stored codes into the applied targets in the same cycle, so a stereo pair can change together. A common-control input makes the left applied code drive both channels.

The live gain codes never jump. A free-running step timer counts sample-rate strobes, and every STEP_DIV strobes each channel moves one code (0.5 dB) toward its aim. Each channel runs a three-state machine: RS_HOLD (gain equals aim), RS_FALL (gain above aim) and RS_RISE (gain below aim). Transitions: RS_HOLD to RS_FALL or RS_RISE when the aim moves away, either ramp state to RS_HOLD when the gain reaches the aim, and RS_FALL to RS_RISE (or back) when the aim crosses the current gain. Soft mute (a register bit, or an active-low pin) sets the aim to 0 without touching the stored codes, so releasing mute ramps back up. A zero watcher with states ZW_OFF (detection disabled), ZW_COUNT (counting consecutive all-zero sample pairs) and ZW_MUTED (run reached) raises automute. Transitions: ZW_OFF to ZW_COUNT when enabled, ZW_COUNT to ZW_MUTED on the ZERO_RUN-th consecutive zero pair, ZW_MUTED to ZW_COUNT on the first non-zero pair, and any state to ZW_OFF when disabled. Automute drives an active-low zero flag and, with operation-disable, reset and both gains at 0, the analogue-mute flag.

Top module: `softmute_gain_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both gain codes read 0xFF and zero_n reads 1; an_mute reads 1 while reset is asserted.
- R2: A write (wr_left or wr_right high) with wr_load at 0 stores the code but leaves both gain targets unchanged.
- R3: A write with wr_load at 1 stores its code and then transfers both stored codes to the left and right targets in the same cycle.
- R4: When common_sel is 1 the left applied code is the target of both channels; when 0 each channel uses its own.
- R5: The step timer counts fs_tick strobes from reset without ever restarting; on the STEP_DIV-th strobe of each period every channel whose gain differs from its aim moves by exactly one code toward it, and at no other time does a gain change.
- R6: Soft mute, active when mute_reg is 1 or mute_pin_n is 0, sets the aim of both channels to 0; the stored codes are kept, so on release the gains ramp back to the applied targets.
- R7: A change of aim during a ramp continues from the current gain code toward the new aim, keeping the step timer phase.
- R8: With zd_en at 1, zero_n falls on the ZERO_RUN-th consecutive fs_tick on which both samples are 0, stays low while zero pairs continue, and rises on the first strobe with a non-zero sample; setting zd_en to 0 releases it and clears the count.
- R9: an_mute is 1 when both gains are 0, or automute is active, or op_dis is 1, or during reset and the first cycle after it; otherwise 0.
- R10: op_dis has no effect on the gain codes or their ramps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_left | input | 1 | Write strobe for the left stored code |
| wr_right | input | 1 | Write strobe for the right stored code |
| wr_code | input | CODE_W | Code written by either strobe |
| wr_load | input | 1 | Load flag of the write: 1 transfers both stored codes to targets |
| common_sel | input | 1 | 1: left applied code drives both channels |
| mute_reg | input | 1 | Soft-mute request from a control bit, active high |
| mute_pin_n | input | 1 | Soft-mute request from a pin, active low |
| op_dis | input | 1 | Operation disable, forces the analogue mute |
| zd_en | input | 1 | Enables the zero-run detector |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| smp_left | input | SAMPLE_W | Left sample, examined on fs_tick |
| smp_right | input | SAMPLE_W | Right sample, examined on fs_tick |
| gain_left | output | CODE_W | Live left gain code |
| gain_right | output | CODE_W | Live right gain code |
| an_mute | output | 1 | Analogue mute flag, active high |
| zero_n | output | 1 | Zero-run flag, active low |

## Verification
On every cycle the assertions confirm that a gain code moves only on a step event and then by exactly one code, that a gain never rises while soft mute is held, that an applied code stays put without a loaded write, and that automute drops after a strobe carrying a non-zero sample. Whether a ramp ends on the right code, keeps its timer phase through a redirection, returns to the stored level after mute, or that the zero flag falls on precisely the ZERO_RUN-th zero pair is shown only by the bench's scenarios, which sweep complete ramps across the whole code range with a small step divisor and run length and compare every strobe against an arithmetic model.

// File: rtl/gr_pkg.sv
package gr_pkg;
    typedef enum logic [1:0] {
        RS_HOLD = 2'd0,
        RS_FALL = 2'd1,
        RS_RISE = 2'd2
    } ramp_state_t;

    typedef enum logic [1:0] {
        ZW_OFF   = 2'd0,
        ZW_COUNT = 2'd1,
        ZW_MUTED = 2'd2
    } zero_state_t;
endpackage

// File: rtl/gr_step_timer.sv
module gr_step_timer #(
    parameter int STEP_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_tick,
    output logic step_ev
);
    localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fs_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign step_ev = fs_tick && (cnt_q == LAST);

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_tick |=> (cnt_q == $past(cnt_q))); // R5
endmodule

// File: rtl/gr_attn_store.sv
module gr_attn_store #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_left,
    input  logic              wr_right,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_load,
    input  logic              common_sel,
    output logic [CODE_W-1:0] tgt_left,
    output logic [CODE_W-1:0] tgt_right
);
    localparam logic [CODE_W-1:0] FULL = '1;

    logic [CODE_W-1:0] held_l_q, held_r_q;
    logic [CODE_W-1:0] held_l_d, held_r_d;
    logic [CODE_W-1:0] appl_l_q, appl_r_q;
    logic              xfer;

    always_comb begin
        held_l_d = wr_left  ? wr_code : held_l_q;
        held_r_d = wr_right ? wr_code : held_r_q;
        xfer     = (wr_left || wr_right) && wr_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_l_q <= FULL;
            held_r_q <= FULL;
            appl_l_q <= FULL;
            appl_r_q <= FULL;
        end else begin
            held_l_q <= held_l_d;
            held_r_q <= held_r_d;
            if (xfer) begin
                appl_l_q <= held_l_d;
                appl_r_q <= held_r_d;
            end
        end
    end

    assign tgt_left  = appl_l_q;
    assign tgt_right = common_sel ? appl_l_q : appl_r_q;

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !((wr_left || wr_right) && wr_load) |=> ($stable(appl_l_q) && $stable(appl_r_q))); // R2
    AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_left && wr_load) |=> (appl_l_q == $past(wr_code))); // R3
endmodule

// File: rtl/gr_ramp_unit.sv
module gr_ramp_unit
    import gr_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_ev,
    input  logic              mute,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] gain
);
    localparam logic [CODE_W-1:0] FULL = '1;
    localparam logic [CODE_W-1:0] NONE = '0;

    ramp_state_t       st_q, st_d;
    logic [CODE_W-1:0] aim;
    logic [CODE_W-1:0] gain_q;

    assign aim = mute ? NONE : target;

    always_comb begin
        if (gain_q == aim) begin
            st_d = RS_HOLD;
        end else if (gain_q < aim) begin
            st_d = RS_RISE;
        end else begin
            st_d = RS_FALL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RS_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= FULL;
        end else if (step_ev) begin
            unique case (st_q)
                RS_RISE: if (gain_q < aim) gain_q <= gain_q + 1'b1;
                RS_FALL: if (gain_q > aim) gain_q <= gain_q - 1'b1;
                RS_HOLD: gain_q <= gain_q;
                default: gain_q <= gain_q;
            endcase
        end
    end

    assign gain = gain_q;

    AST_MOVE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q != $past(gain_q)) |-> $past(step_ev)); // R5
    AST_ONE_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q != $past(gain_q)) |->
            (gain_q == $past(gain_q) + 1'b1 || gain_q == $past(gain_q) - 1'b1)); // R5
    AST_NO_RISE_IN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && $past(mute)) |-> (gain_q <= $past(gain_q))); // R6
endmodule

// File: rtl/gr_zero_watch.sv
module gr_zero_watch
    import gr_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ZERO_RUN = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                zd_en,
    input  logic                fs_tick,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                automute
);
    localparam int CW = $clog2(ZERO_RUN + 1);
    localparam logic [CW-1:0] RUN_LEN = CW'(ZERO_RUN);

    zero_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pair_zero;

    assign pair_zero = (smp_left == '0) && (smp_right == '0);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!zd_en) begin
            st_d  = ZW_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ZW_OFF: begin
                    st_d  = ZW_COUNT;
                    cnt_d = '0;
                end
                ZW_COUNT: begin
                    if (fs_tick) begin
                        if (pair_zero) begin
                            cnt_d = cnt_q + 1'b1;
                            if (cnt_q + 1'b1 == RUN_LEN) st_d = ZW_MUTED;
                        end else begin
                            cnt_d = '0;
                        end
                    end
                end
                ZW_MUTED: begin
                    if (fs_tick && !pair_zero) begin
                        st_d  = ZW_COUNT;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = ZW_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ZW_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        automute = (st_q == ZW_MUTED);
    end

    AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_tick && !pair_zero) |=> !automute); // R8
    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !zd_en |=> !automute); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RUN_LEN); // R8
endmodule

// File: rtl/softmute_gain_ctrl.sv
module softmute_gain_ctrl #(
    parameter int CODE_W   = 8,
    parameter int SAMPLE_W = 24,
    parameter int STEP_DIV = 128,
    parameter int ZERO_RUN = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_left,
    input  logic                wr_right,
    input  logic [CODE_W-1:0]   wr_code,
    input  logic                wr_load,
    input  logic                common_sel,
    input  logic                mute_reg,
    input  logic                mute_pin_n,
    input  logic                op_dis,
    input  logic                zd_en,
    input  logic                fs_tick,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic [CODE_W-1:0]   gain_left,
    output logic [CODE_W-1:0]   gain_right,
    output logic                an_mute,
    output logic                zero_n
);
    localparam int NCH = 2;

    logic              step_ev;
    logic              mute_any;
    logic              automute;
    logic              run_q;
    logic [CODE_W-1:0] tgt  [NCH];
    logic [CODE_W-1:0] gain [NCH];

    assign mute_any = mute_reg || !mute_pin_n;

    gr_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_tick (fs_tick),
        .step_ev (step_ev)
    );

    gr_attn_store #(.CODE_W(CODE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_left    (wr_left),
        .wr_right   (wr_right),
        .wr_code    (wr_code),
        .wr_load    (wr_load),
        .common_sel (common_sel),
        .tgt_left   (tgt[0]),
        .tgt_right  (tgt[1])
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gr_ramp_unit #(.CODE_W(CODE_W)) u_ramp (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_ev (step_ev),
            .mute    (mute_any),
            .target  (tgt[c]),
            .gain    (gain[c])
        );
    end

    gr_zero_watch #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .zd_en     (zd_en),
        .fs_tick   (fs_tick),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .automute  (automute)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    always_comb begin
        gain_left  = gain[0];
        gain_right = gain[1];
        zero_n     = !automute;
        an_mute    = !run_q || automute || op_dis ||
                     ((gain[0] == '0) && (gain[1] == '0));
    end

    AST_DIS_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dis && !step_ev) |=> ($stable(gain_left) && $stable(gain_right))); // R10
    AST_COMMON_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (common_sel && $past(common_sel) && $past(gain_left) == $past(gain_right))
            |-> (gain_left == gain_right)); // R4
endmodule

// File: tb/sim_softmute_gain_ctrl.sv
module sim_softmute_gain_ctrl;
    localparam int CW  = 8;
    localparam int SW  = 16;
    localparam int DIV = 4;
    localparam int RUN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_left = 0, wr_right = 0, wr_load = 0;
    logic [CW-1:0] wr_code = '0;
    logic          common_sel = 0, mute_reg = 0, mute_pin_n = 1, op_dis = 0, zd_en = 0;
    logic          fs_tick = 0;
    logic [SW-1:0] smp_left = '0, smp_right = '0;
    logic [CW-1:0] gain_left, gain_right;
    logic          an_mute, zero_n;

    always #2 clk = ~clk;

    softmute_gain_ctrl #(.CODE_W(CW), .SAMPLE_W(SW), .STEP_DIV(DIV), .ZERO_RUN(RUN)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_left(wr_left), .wr_right(wr_right),
        .wr_code(wr_code), .wr_load(wr_load), .common_sel(common_sel),
        .mute_reg(mute_reg), .mute_pin_n(mute_pin_n), .op_dis(op_dis),
        .zd_en(zd_en), .fs_tick(fs_tick), .smp_left(smp_left), .smp_right(smp_right),
        .gain_left(gain_left), .gain_right(gain_right), .an_mute(an_mute), .zero_n(zero_n)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int sl = 255, sr = 255, al = 255, ar = 255;
    int eg [2] = '{255, 255};
    int tcnt = 0, zc = 0;
    bit am = 0;

    function automatic int aim_of(int c);
        if (mute_reg || !mute_pin_n) return 0;
        if (c == 0 || common_sel) return al;
        return ar;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk({req, " gain_left"}, gain_left, eg[0]);
        chk({req, " gain_right"}, gain_right, eg[1]);
        chk({req, " zero_n"}, zero_n, !am);
        chk({req, " an_mute"}, an_mute, am || op_dis || (eg[0] == 0 && eg[1] == 0));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(int l, int r, string req);
        smp_left = SW'(l); smp_right = SW'(r);
        fs_tick = 1;
        @(negedge clk);
        fs_tick = 0;
        tcnt++;
        if (tcnt % DIV == 0) begin
            for (int c = 0; c < 2; c++) begin
                int a = aim_of(c);
                if (eg[c] < a) eg[c]++;
                else if (eg[c] > a) eg[c]--;
            end
        end
        if (zd_en) begin
            if (l == 0 && r == 0) begin
                if (zc < RUN) zc++;
                am = (zc == RUN);
            end else begin
                zc = 0; am = 0;
            end
        end
        check_all(req);
        idle(1);
    endtask

    task automatic write(bit left, int code, bit load);
        wr_left = left; wr_right = !left; wr_code = CW'(code); wr_load = load;
        @(negedge clk);
        wr_left = 0; wr_right = 0; wr_load = 0;
        if (left) sl = code; else sr = code;
        if (load) begin al = sl; ar = sr; end
        idle(1);
    endtask

    task automatic settle(string req);
        int guard = 0;
        while ((eg[0] != aim_of(0) || eg[1] != aim_of(1)) && guard < 2000) begin
            tick(1, 1, req);
            guard++;
        end
        for (int k = 0; k < DIV + 1; k++) tick(1, 1, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 / R9: state under reset
        idle(3);
        chk("R9 an_mute in reset", an_mute, 1);
        chk("R1 gain_left in reset", gain_left, 255);
        chk("R1 gain_right in reset", gain_right, 255);
        chk("R1 zero_n in reset", zero_n, 1);
        rst_n = 1;
        idle(2);
        check_all("R1");

        // R2: store without load
        write(1, 240, 0);
        for (int k = 0; k < 3 * DIV; k++) tick(1, 1, "R2");

        // R3 / R5: loaded write applies both stored codes
        write(0, 232, 1);
        settle("R3/R5");

        // R4: common control
        common_sel = 1; idle(2);
        settle("R4");
        common_sel = 0; idle(2);
        settle("R4 release");

        // R6: soft mute by register down to 0 and back
        mute_reg = 1; idle(2);
        settle("R6 mute_reg");
        mute_reg = 0; idle(2);
        settle("R6 unmute");

        // R7: pin mute released mid-ramp, then retarget mid-ramp
        mute_pin_n = 0; idle(2);
        for (int k = 0; k < 10 * DIV + 2; k++) tick(1, 1, "R7 pin mute");
        mute_pin_n = 1; idle(2);
        for (int k = 0; k < 3 * DIV + 1; k++) tick(1, 1, "R7 release");
        write(1, 200, 1);
        for (int k = 0; k < 5 * DIV + 3; k++) tick(1, 1, "R7 retarget");
        write(0, 255, 1);
        settle("R7");

        // R10: op_dis leaves gains and ramps alone
        op_dis = 1; idle(2);
        for (int k = 0; k < 2 * DIV; k++) tick(1, 1, "R10 idle");
        write(1, 180, 1);
        settle("R10 ramp");
        op_dis = 0; idle(2);
        check_all("R10 off");

        // R8: zero-run detection
        zd_en = 1; idle(2);
        for (int k = 0; k < RUN - 1; k++) tick(0, 0, "R8 below run");
        tick(0, 0, "R8 at run");
        chk("R8 zero_n low", zero_n, 0);
        for (int k = 0; k < 3; k++) tick(0, 0, "R8 held");
        tick(0, 5, "R8 release");
        chk("R8 zero_n released", zero_n, 1);
        for (int k = 0; k < RUN - 2; k++) tick(0, 0, "R8 recount");
        tick(3, 0, "R8 left nonzero");
        for (int k = 0; k < RUN; k++) tick(0, 0, "R8 second run");
        zd_en = 0; idle(1);
        zc = 0; am = 0;
        idle(1);
        check_all("R8 disable");
        for (int k = 0; k < RUN + 2; k++) tick(0, 0, "R8 disabled");

        // R9: both gains at 0 through loaded codes
        write(1, 0, 0);
        write(0, 0, 1);
        settle("R9 both zero");
        write(1, 1, 1);
        settle("R9 one nonzero");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule